// File: doc/BRIEF.md
# SMBus Host-Notify Receiver

This block sits on the host side of a two-wire system-management bus. It listens as a slave for the one message a device sends when it takes the bus as master to alert the host. That message has the shape of a word write. The first byte is the host's own address with the write bit clear. The byte after it carries the alerting device's address in place of a register selector. Two status bytes follow, low byte first. The receiver pulls the data line low to acknowledge each of these four bytes. Once a STOP closes a well-formed message, it hands the device address and the 16-bit status word to a consumer over a valid/ready slot.

The raw clock and data lines pass through a synchroniser. The synchronised levels are then turned into four events: START, STOP, clock rise and clock fall. A state machine works on these events. Its states are ST_IDLE (bus free or message abandoned), ST_SHIFT (collecting eight bits of a byte), ST_ACK (holding the data line low for the ninth clock), ST_HOLD (three payload bytes taken, waiting for STOP) and ST_SKIP (message not for the host or malformed, waiting for the bus to go free). The transitions are:

- START from any state goes to ST_SHIFT.
- STOP from any state goes to ST_IDLE. Only the STOP leaving ST_HOLD posts a notification.
- ST_SHIFT goes to ST_ACK on the clock fall after the eighth bit. The exception is the first byte when it does not match; that goes to ST_SKIP.
- ST_ACK goes to ST_SHIFT on the next clock fall. After the fourth byte it goes to ST_HOLD instead.
- ST_HOLD goes to ST_SKIP if a full clock pulse arrives before STOP.

Only one posted notification is held at a time. A second one that completes while the first is unread is dropped, and this is flagged as an overflow.

Top module: `smb_notify_rx`

## Requirements
- R1: After reset, `note_valid` and `note_overflow` are 0 and `sda_pull` is 0 (data line released).
- R2: When the first byte after START equals {HOST_ADDR, 0} (0x18 for HOST_ADDR 0x0C), `sda_pull` is 1 during the ninth clock-high period of that byte.
- R3: Each of the three bytes that follow a matching first byte is acknowledged in its ninth clock period.
- R4: A first byte that differs from {HOST_ADDR, 0} is not acknowledged. This covers a different address and the read bit set. The bytes after it are not acknowledged and nothing is posted.
- R5: A STOP that follows exactly three acknowledged bytes after the address posts a notification. `note_dev` is the second byte's bits 7..1, and `note_status` is {fourth byte, third byte}.
- R6: A STOP after fewer than three bytes following the address posts nothing.
- R7: If the master clocks a fourth byte after the address, that byte is not acknowledged and the message posts nothing.
- R8: While `note_valid` is 1 and `note_ready` is 0, `note_valid`, `note_dev` and `note_status` hold. The cycle after `note_ready` is seen with `note_valid`, `note_valid` is 0.
- R9: A notification that completes while `note_valid` is 1 and `note_ready` is 0 sets `note_overflow` and leaves the held notification unchanged. The handshake clears `note_overflow`.
- R10: A repeated START in the middle of a message abandons it and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| note_valid | output | 1 | A notification is waiting |
| note_ready | input | 1 | Consumer takes the notification |
| note_dev | output | 7 | Address of the notifying device |
| note_status | output | 16 | Status word from the notification |
| note_overflow | output | 1 | A later notification was dropped |

## Verification
The bench builds the block with HOST_ADDR set to 0x0C rather than the default 0x08. Because of this, the default's address byte 0x10 can be sent as a foreign address, and a hard-wired match would be exposed. SYNC_STAGES is set to 3. This pushes event latency to four clocks, so the acknowledge window has to track the delayed clock fall and not the raw edge.

// File: rtl/smbn_pkg.sv
package smbn_pkg;

    localparam int BYTE_BITS = 8;
    localparam int DEV_BITS  = 7;
    localparam int WORD_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } rx_state_t;

    typedef struct packed {
        logic [DEV_BITS-1:0]  dev;
        logic [WORD_BITS-1:0] status;
    } notice_t;

endpackage

// File: rtl/smbn_line_sampler.sv
module smbn_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    always_comb begin
        ev_rise  = scl_lvl & ~scl_prev;
        ev_fall  = ~scl_lvl & scl_prev;
        ev_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        ev_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/smbn_frame_fsm.sv
module smbn_frame_fsm
    import smbn_pkg::*;
#(
    parameter logic [6:0] HOST_ADDR = 7'h08
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_lvl,
    input  logic    sda_lvl,
    input  logic    ev_start,
    input  logic    ev_stop,
    input  logic    ev_rise,
    input  logic    ev_fall,
    output logic    sda_pull,
    output logic    post,
    output notice_t notice
);

    localparam int          CNT_W    = $clog2(BYTE_BITS + 1);
    localparam int          LAST_IDX = 3;
    localparam logic [7:0]  MATCH    = {HOST_ADDR, 1'b0};

    rx_state_t               state, state_nx;
    logic [CNT_W-1:0]        bit_cnt;
    logic [BYTE_BITS-1:0]    shreg;
    logic [1:0]              byte_idx;
    logic [DEV_BITS-1:0]     dev_q;
    logic [BYTE_BITS-1:0]    lo_q;
    logic [BYTE_BITS-1:0]    hi_q;
    logic                    byte_done;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_BITS)) && ev_fall;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ev_start) begin
            state_nx = ST_SHIFT;
        end else if (ev_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_SHIFT: begin
                    if (byte_done) begin
                        if (byte_idx == 2'd0 && shreg != MATCH)
                            state_nx = ST_SKIP;
                        else
                            state_nx = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (ev_fall)
                        state_nx = (byte_idx == 2'(LAST_IDX)) ? ST_HOLD : ST_SHIFT;
                end
                ST_HOLD: begin
                    if (ev_fall)
                        state_nx = ST_SKIP;
                end
                ST_SKIP:  state_nx = ST_SKIP;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            dev_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            state <= state_nx;
            if (ev_start) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else if (state == ST_SHIFT) begin
                if (ev_rise && bit_cnt != CNT_W'(BYTE_BITS)) begin
                    shreg   <= {shreg[BYTE_BITS-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done && state_nx == ST_ACK) begin
                    unique case (byte_idx)
                        2'd1:    dev_q <= shreg[7:1];
                        2'd2:    lo_q  <= shreg;
                        2'd3:    hi_q  <= shreg;
                        default: ;
                    endcase
                end
            end else if (state == ST_ACK && ev_fall) begin
                bit_cnt <= '0;
                if (byte_idx != 2'(LAST_IDX))
                    byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post   <= 1'b0;
            notice <= '0;
        end else begin
            post   <= (state == ST_HOLD) && ev_stop && !ev_start;
            notice <= '{dev: dev_q, status: {hi_q, lo_q}};
        end
    end

    assign sda_pull = (state == ST_ACK);

    // R2, R3: the acknowledge begins only while the clock line is low
    a_r2_ack_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);

    // R5: a post only follows a STOP event
    a_r5_post_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> $past(ev_stop));

endmodule

// File: rtl/smbn_notice_slot.sv
module smbn_notice_slot
    import smbn_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    post,
    input  notice_t notice_in,
    input  logic    ready,
    output logic    valid,
    output notice_t notice_out,
    output logic    ovf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid      <= 1'b0;
            ovf        <= 1'b0;
            notice_out <= '0;
        end else begin
            if (valid && ready) begin
                valid <= 1'b0;
                ovf   <= 1'b0;
            end
            if (post) begin
                if (!valid || ready) begin
                    valid      <= 1'b1;
                    notice_out <= notice_in;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end

    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(notice_out));

    a_r8_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && !post |=> !valid);

    a_r9_overflow_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(valid) && valid);

    a_r9_keep_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(notice_out));

endmodule

// File: rtl/smb_notify_rx.sv
module smb_notify_rx
    import smbn_pkg::*;
#(
    parameter logic [6:0] HOST_ADDR   = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    output logic        note_valid,
    input  logic        note_ready,
    output logic [6:0]  note_dev,
    output logic [15:0] note_status,
    output logic        note_overflow
);

    logic    scl_lvl, sda_lvl;
    logic    ev_start, ev_stop, ev_rise, ev_fall;
    logic    post;
    notice_t fresh, held;

    smbn_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    smbn_frame_fsm #(.HOST_ADDR(HOST_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .sda_pull (sda_pull),
        .post     (post),
        .notice   (fresh)
    );

    smbn_notice_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .post       (post),
        .notice_in  (fresh),
        .ready      (note_ready),
        .valid      (note_valid),
        .notice_out (held),
        .ovf        (note_overflow)
    );

    assign note_dev    = held.dev;
    assign note_status = held.status;

endmodule

// File: tb/sim_smb_notify_rx.sv
`timescale 1ns/1ps
module sim_smb_notify_rx;

    localparam logic [6:0] HOST = 7'h0C;
    localparam logic [7:0] ADDR_WR = {HOST, 1'b0};
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic note_ready = 1'b0;
    logic sda_pull, note_valid, note_overflow;
    logic [6:0] note_dev;
    logic [15:0] note_status;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    logic last_ack;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    smb_notify_rx #(.HOST_ADDR(HOST), .SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .note_valid(note_valid), .note_ready(note_ready),
        .note_dev(note_dev), .note_status(note_status), .note_overflow(note_overflow)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(4*Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(2*Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        last_ack = ~sda_line;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic take();
        note_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        note_ready = 1'b0;
    endtask

    task automatic full_msg(input logic [7:0] devb, input logic [7:0] lo, input logic [7:0] hi);
        bus_start();
        send_byte(ADDR_WR); check(last_ack, "R2 address ack", last_ack, 1);
        send_byte(devb);    check(last_ack, "R3 device byte ack", last_ack, 1);
        send_byte(lo);      check(last_ack, "R3 low byte ack", last_ack, 1);
        send_byte(hi);      check(last_ack, "R3 high byte ack", last_ack, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        check(!note_valid, "R1 valid at reset", note_valid, 0);
        check(!note_overflow, "R1 overflow at reset", note_overflow, 0);
        check(!sda_pull, "R1 line released", sda_pull, 0);
    endtask

    task automatic t_basic();
        full_msg(8'h5A, 8'h34, 8'h12);
        check(note_valid, "R5 posted", note_valid, 1);
        check(note_dev == 7'h2D, "R5 device address", note_dev, 7'h2D);
        check(note_status == 16'h1234, "R5 status word", note_status, 16'h1234);
        wait_clk(20);
        check(note_valid && note_status == 16'h1234, "R8 held without ready", note_status, 16'h1234);
        take();
        check(!note_valid, "R8 cleared after take", note_valid, 0);
    endtask

    task automatic t_foreign();
        bus_start();
        send_byte(8'h10); check(!last_ack, "R4 foreign address no ack", last_ack, 0);
        send_byte(8'h22); check(!last_ack, "R4 later byte no ack", last_ack, 0);
        send_byte(8'h33);
        send_byte(8'h44);
        bus_stop();
        check(!note_valid, "R4 nothing posted", note_valid, 0);
        bus_start();
        send_byte({HOST, 1'b1}); check(!last_ack, "R4 read bit no ack", last_ack, 0);
        bus_stop();
        check(!note_valid, "R4 read nothing posted", note_valid, 0);
    endtask

    task automatic t_short();
        bus_start();
        send_byte(ADDR_WR);
        send_byte(8'h40);
        send_byte(8'h01);
        bus_stop();
        check(!note_valid, "R6 short message dropped", note_valid, 0);
    endtask

    task automatic t_long();
        bus_start();
        send_byte(ADDR_WR);
        send_byte(8'h40);
        send_byte(8'h01);
        send_byte(8'h02);
        send_byte(8'h03); check(!last_ack, "R7 fourth byte no ack", last_ack, 0);
        bus_stop();
        check(!note_valid, "R7 long message dropped", note_valid, 0);
    endtask

    task automatic t_overflow();
        full_msg(8'h20, 8'hCD, 8'hAB);
        check(note_valid && !note_overflow, "R9 first held", note_overflow, 0);
        full_msg(8'h60, 8'h11, 8'h22);
        check(note_overflow, "R9 overflow set", note_overflow, 1);
        check(note_dev == 7'h10 && note_status == 16'hABCD, "R9 held unchanged", note_status, 16'hABCD);
        take();
        check(!note_valid && !note_overflow, "R9 cleared by take", {note_valid, note_overflow}, 0);
    endtask

    task automatic t_restart();
        bus_start();
        send_byte(ADDR_WR);
        send_byte(8'h7E);
        bus_start();
        full_msg(8'h0C, 8'h78, 8'h56);
        check(note_valid && note_dev == 7'h06 && note_status == 16'h5678, "R10 restart posts new message",
              note_status, 16'h5678);
        take();
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_basic();
        t_foreign();
        t_short();
        t_long();
        t_overflow();
        t_restart();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule